// File: doc/BRIEF.md
# Glitch-Rejecting Serial Filter (One-Hot Nondeterministic Recognizer)

This block cleans a single serial bit stream. Its output follows the input's level, but a burst of one or two cycles that disagrees with the bits around it is not allowed to change the output. The filter is not built as a counter. It is a one-hot nondeterministic recognizer for the pattern "any prefix, then a run of three ones, then any number of groups made of a one followed by zero, one or two zeros". Each operand of that pattern owns one flip-flop. Several of these flip-flops may be set at the same time. The output is high in exactly the cycles in which the input seen so far ends in a string of that pattern.

The logic is laid out like a two-plane array. In the product plane, each term checks one active state flip-flop, or the start pulse, together with the input level that term needs. In the sum plane, each next-state bit and the output bit is the OR of every term that taps it. A state that no term taps in a cycle is cleared on the next edge. After a synchronous reset every state is clear. Recognition begins only with a start pulse, which seeds the initial states. The input bit sampled on the start cycle counts as the first bit of the stream.

Top module: `glitch_nfa_filter`

## Requirements
- R1: A synchronous reset clears every state flip-flop, and the output reads 0 after the reset edge. A reset applied while the output is high drives it to 0 at that edge.
- R2: Until the first start pulse after reset, the output stays 0 whatever the input does.
- R3: The input bit sampled on the cycle with start high is the first bit of the recognized stream. After start with input 1, followed by one more 1, the output is still 0.
- R4: The output becomes 1 on the clock edge that samples the third consecutive 1 counted from the start cycle. It is registered on that same edge.
- R5: While the output is high, a burst of one or two 0 bits followed by a 1 keeps the output at 1 throughout.
- R6: While the output is high, the edge that samples a third consecutive 0 drives the output to 0. After only two zeros the output is still 1.
- R7: While the output is low after a run of three or more zeros, a burst of one or two 1 bits followed by a 0 keeps the output at 0 throughout.
- R8: A start pulse while recognition is already running has no effect on the output. This holds with the output high and with it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that seeds the initial states |
| din | input | 1 | Serial input bit, sampled each edge |
| dout | output | 1 | Filtered output, registered |

## Verification
The embedded properties assume that reset is applied before anything else, so every flip-flop holds a known value. They also assume that start and din are synchronous and stable around the rising edge. Under these assumptions the rise and fall properties may relate the output change to the single previous input sample. The bench changes every input on the falling edge. It asserts reset for a full cycle before each table row. Its random stretch never touches reset, so the one-cycle look-back in the properties always falls inside a recognized run.

// File: rtl/glf_pkg.sv
package glf_pkg;

   // Recognizer geometry: six fed-back operand states plus one output column
   localparam int NFEED     = 6;
   localparam int NCOL      = NFEED + 1;
   localparam int COL_OUT   = NFEED;
   localparam int NTERM     = 8;
   localparam int SRC_START = NFEED;   // term source index meaning "start pin"

   typedef enum logic [1:0] {
      LIT_ANY  = 2'd0,
      LIT_ONE  = 2'd1,
      LIT_ZERO = 2'd2
   } lit_e;

   // Product-plane personality: which state (or start) feeds each term
   localparam int TERM_SRC [NTERM] = '{0, 1, 2, 3, 4, 5, SRC_START, SRC_START};

   // Required input level for each term
   localparam lit_e TERM_LIT [NTERM] = '{LIT_ANY, LIT_ONE, LIT_ONE, LIT_ONE,
                                         LIT_ZERO, LIT_ZERO, LIT_ANY, LIT_ONE};

   // Sum-plane taps, bit c = column c (columns 0..5 states, 6 output)
   localparam logic [NCOL-1:0] TERM_TAP [NTERM] = '{
      7'b0000011,   // first state loops, arms second
      7'b0000100,   // second state on 1 -> third
      7'b0001000,   // third state on 1 -> group head
      7'b1111000,   // group head on 1 -> head, both zero slots, output
      7'b1101000,   // first zero slot on 0 -> head, second slot, output
      7'b1001000,   // second zero slot on 0 -> head, output
      7'b0000011,   // start seeds the two initial states
      7'b0000100    // start with 1 acts as the second state's term
   };

   function automatic logic [NTERM-1:0] col_mask(input int c);
      logic [NTERM-1:0] m;
      for (int t = 0; t < NTERM; t++) m[t] = TERM_TAP[t][c];
      return m;
   endfunction

endpackage

// File: rtl/glf_and_plane.sv
module glf_and_plane #(
   parameter int NFEED = glf_pkg::NFEED,
   parameter int NTERM = glf_pkg::NTERM
) (
   input  logic [NFEED-1:0] st,
   input  logic             start,
   input  logic             din,
   output logic [NTERM-1:0] term
);
   import glf_pkg::*;

   for (genvar t = 0; t < NTERM; t++) begin : g_term
      logic src;
      if (TERM_SRC[t] == SRC_START) begin : g_from_start
         assign src = start;
      end else begin : g_from_state
         assign src = st[TERM_SRC[t]];
      end

      if (TERM_LIT[t] == LIT_ANY) begin : g_any
         assign term[t] = src;
      end else if (TERM_LIT[t] == LIT_ONE) begin : g_one
         assign term[t] = src & din;
      end else begin : g_zero
         assign term[t] = src & ~din;
      end
   end

endmodule

// File: rtl/glf_or_plane.sv
module glf_or_plane #(
   parameter int NTERM = glf_pkg::NTERM,
   parameter int NCOL  = glf_pkg::NCOL
) (
   input  logic [NTERM-1:0] term,
   output logic [NCOL-1:0]  col
);
   import glf_pkg::*;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      localparam logic [NTERM-1:0] MASK = col_mask(c);
      assign col[c] = |(term & MASK);
   end

endmodule

// File: rtl/glf_state_bank.sv
module glf_state_bank #(
   parameter int W = glf_pkg::NCOL
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst) q[b] <= 1'b0;
         else     q[b] <= d[b];
      end
   end

endmodule

// File: rtl/glitch_nfa_filter.sv
module glitch_nfa_filter #(
   parameter int NFEED = glf_pkg::NFEED,
   parameter int NTERM = glf_pkg::NTERM
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic din,
   output logic dout
);
   import glf_pkg::*;

   localparam int NCOLS = NFEED + 1;

   if (NFEED != glf_pkg::NFEED) begin : g_chk_feed
      $error("NFEED must match the recognizer personality");
   end
   if (NTERM != glf_pkg::NTERM) begin : g_chk_term
      $error("NTERM must match the recognizer personality");
   end

   logic [NCOLS-1:0] q;
   logic [NCOLS-1:0] nxt;
   logic [NTERM-1:0] term;
   logic [NFEED-1:0] st;

   assign st   = q[NFEED-1:0];
   assign dout = q[COL_OUT];

   glf_and_plane #(.NFEED(NFEED), .NTERM(NTERM)) u_and (
      .st(st), .start(start), .din(din), .term(term));

   glf_or_plane #(.NTERM(NTERM), .NCOL(NCOLS)) u_or (
      .term(term), .col(nxt));

   glf_state_bank #(.W(NCOLS)) u_bank (
      .clk(clk), .rst(rst), .d(nxt), .q(q));

   // Nothing wakes up without a start pulse
   AST_IDLE_WITHOUT_START: assert property (@(posedge clk) disable iff (rst)
      (st == '0 && !start) |=> (st == '0 && !dout)); // R2

   // Start seeds the two initial states
   AST_START_SEEDS: assert property (@(posedge clk) disable iff (rst)
      start |=> (st[0] && st[1])); // R3

   // Once seeded, the prefix state never drops out
   AST_PREFIX_PERSISTS: assert property (@(posedge clk) disable iff (rst)
      st[0] |=> (st[0] && st[1])); // R8

   // Output can only rise on a sampled 1
   AST_RISE_ON_ONE: assert property (@(posedge clk) disable iff (rst)
      $rose(dout) |-> $past(din)); // R4

   // Output can only fall on a sampled 0
   AST_FALL_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
      $fell(dout) |-> !$past(din)); // R6

   // High output always leaves the group-head state active
   AST_OUT_WITH_HEAD: assert property (@(posedge clk) disable iff (rst)
      dout |-> st[3]); // R5

endmodule

// File: tb/glitch_nfa_filter_test.sv
module glitch_nfa_filter_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   // {expected final output, length, pattern (applied MSB-first of low bits)}
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b1, 4'd3, 12'b000000000111},
      {1'b0, 4'd3, 12'b000000000110},
      {1'b1, 4'd4, 12'b000000001110},
      {1'b1, 4'd5, 12'b000000011100},
      {1'b0, 4'd6, 12'b000000111000},
      {1'b0, 4'd7, 12'b000001110001},
      {1'b1, 4'd9, 12'b000111000111},
      {1'b0, 4'd4, 12'b000000001101},
      {1'b1, 4'd4, 12'b000000000111},
      {1'b1, 4'd8, 12'b000011101001},
      {1'b0, 4'd7, 12'b000001011011},
      {1'b0, 4'd9, 12'b000111001000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic din = 1'b0;
   logic dout;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bit m_started = 1'b0;
   bit m_armed = 1'b0;
   int m_ones = 0;
   int m_zeros = 0;

   glitch_nfa_filter uut (
      .clk(clk), .rst(rst), .start(start), .din(din), .dout(dout));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_started = 1'b0; m_armed = 1'b0; m_ones = 0; m_zeros = 0;
   endtask

   // Run-length model: arm on three ones in a row, disarm on three zeros
   task automatic model_step(input logic xv, input logic sv);
      if (sv) m_started = 1'b1;
      if (m_started) begin
         if (xv) begin
            m_zeros = 0;
            if (m_ones < 3) m_ones++;
            if (m_ones == 3) m_armed = 1'b1;
         end else begin
            m_ones = 0;
            if (m_zeros < 3) m_zeros++;
            if (m_zeros == 3) m_armed = 1'b0;
         end
      end
   endtask

   task automatic step(input logic xv, input logic sv, input string req, input bit chk);
      @(negedge clk);
      din = xv; start = sv;
      @(posedge clk);
      model_step(xv, sv);
      #1;
      if (chk) check(dout, m_armed, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; start = 1'b0; din = 1'b0;
      @(posedge clk);
      model_clear();
      #1;
      check(dout, 1'b0, "R1");
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not end, dout=%b expected=done", dout);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic cur;
      // R1: reset state
      do_reset();

      // R2: no start, output must stay low
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R2", 1'b1);

      // Table walk: each row from reset, start on first bit
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         for (int b = int'(VEC[v][15:12]) - 1; b >= 0; b--)
            step(VEC[v][b], (b == int'(VEC[v][15:12]) - 1), "R4", 1'b0);
         check(dout, VEC[v][16], "R4 table row");
      end

      // R3: start cycle bit counts; two ones not enough
      do_reset();
      step(1'b1, 1'b1, "R3", 1'b0);
      step(1'b1, 1'b0, "R3", 1'b0);
      check(dout, 1'b0, "R3");
      step(1'b1, 1'b0, "R4", 1'b0);
      check(dout, 1'b1, "R4");

      // R5: short low bursts while high
      step(1'b1, 1'b0, "R5", 1'b1);
      step(1'b0, 1'b0, "R5", 1'b0); check(dout, 1'b1, "R5");
      step(1'b1, 1'b0, "R5", 1'b0); check(dout, 1'b1, "R5");
      step(1'b0, 1'b0, "R5", 1'b0); check(dout, 1'b1, "R5");
      step(1'b0, 1'b0, "R5", 1'b0); check(dout, 1'b1, "R5");
      step(1'b1, 1'b0, "R5", 1'b0); check(dout, 1'b1, "R5");

      // R8: start pulse while high
      step(1'b1, 1'b1, "R8", 1'b0); check(dout, 1'b1, "R8");

      // R6: three zeros drop the output
      step(1'b0, 1'b0, "R6", 1'b0);
      step(1'b0, 1'b0, "R6", 1'b0); check(dout, 1'b1, "R6");
      step(1'b0, 1'b0, "R6", 1'b0); check(dout, 1'b0, "R6");

      // R7: short high bursts while low
      step(1'b0, 1'b0, "R7", 1'b1);
      step(1'b1, 1'b0, "R7", 1'b0); check(dout, 1'b0, "R7");
      step(1'b0, 1'b0, "R7", 1'b0); check(dout, 1'b0, "R7");
      step(1'b1, 1'b0, "R7", 1'b0); check(dout, 1'b0, "R7");
      step(1'b1, 1'b0, "R7", 1'b0); check(dout, 1'b0, "R7");
      step(1'b0, 1'b0, "R7", 1'b0); check(dout, 1'b0, "R7");

      // R8: start pulse while low, then only two ones
      step(1'b0, 1'b0, "R8", 1'b1);
      step(1'b1, 1'b1, "R8", 1'b0); check(dout, 1'b0, "R8");
      step(1'b1, 1'b0, "R8", 1'b0); check(dout, 1'b0, "R8");

      // R1: reset while high
      step(1'b1, 1'b0, "R4", 1'b1);
      step(1'b1, 1'b0, "R4", 1'b0); check(dout, 1'b1, "R4");
      do_reset();

      // Random stream with injected short glitches vs run-length model
      do_reset();
      cur = 1'b1;
      step(cur, 1'b1, "R4", 1'b1);
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom % 10);
         if (r == 0) cur = ~cur;
         step((r == 1 || r == 2) ? ~cur : cur, (r == 3), "R4/R5/R6/R7 random", 1'b1);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule